// File: doc/BRIEF.md
# Floating-Point Load-Multiple Sequencer

This block carries out one block-transfer load into a run of consecutive floating-point registers. A decoder upstream hands it a request already decoded: the base address, the first destination register, an 8-bit word count and four mode bits. The mode bits choose single or double precision, an ascending or descending transfer window, whether the base gets an updated value, and big or little word order. The block reads 32-bit words one at a time through a valid/ready read port that is followed by a one-cycle response strobe. Each finished register goes out through a register-file write port.

In single-precision mode every word fills one register. In double-precision mode two neighbouring words are joined into one 64-bit register. Word order decides which of the two words becomes the upper half. At the end, a one-cycle completion pulse carries the new base value and a write enable for it. Requests that would run past the last register are refused with an error flag. A zero-length request completes at once.

Top module: `fp_multi_loader`

## Requirements
- R1: The first read address is the base when the add flag is set, and base minus 4×count when it is clear. Each later read address is 4 above the one before it.
- R2: In single mode (req_dbl=0) each response word produces one register write, with the word in rf_data[31:0], zeros in rf_data[63:32] and rf_dbl low.
- R3: In double mode (req_dbl=1) each register uses two reads at consecutive addresses. With req_big=1 the first word goes into rf_data[63:32] and the second into [31:0]. With req_big=0 the placement is reversed. rf_dbl is high.
- R4: Register writes go to ascending indices starting at req_start. There are count writes in single mode and count>>1 in double mode, where count bit 0 plays no part in the register count.
- R5: On the completion pulse, base_we equals the writeback flag for a request without error. base_val is base+4×count when adding and base−4×count when subtracting.
- R6: A request with no registers to load issues no read and no write, and its completion pulse comes on the first cycle after acceptance.
- R7: If start plus the register count exceeds the 32-entry file, done_err is raised with the completion pulse on the first cycle after acceptance. No read or write is made and base_we stays low.
- R8: Once raised, mem_rd_valid stays high with mem_rd_addr unchanged until a cycle in which mem_rd_ready is high.
- R9: busy is high from the cycle after acceptance through the completion cycle. req_valid and all request fields are ignored while busy is high.
- R10: done is a single-cycle pulse. The cycle after it has both done and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_base | input | 32 | Base address value |
| req_start | input | 5 | First destination register index |
| req_count | input | 8 | Transfer length in 32-bit words |
| req_dbl | input | 1 | 1 = 64-bit registers, 0 = 32-bit registers |
| req_add | input | 1 | 1 = window starts at base, 0 = window ends at base |
| req_wback | input | 1 | Request base writeback |
| req_big | input | 1 | 1 = first word is upper half |
| busy | output | 1 | Transfer in progress |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_ready | input | 1 | Read request taken |
| mem_rsp_valid | input | 1 | One-cycle read data strobe |
| mem_rsp_data | input | 32 | Read data |
| rf_we | output | 1 | Register write enable |
| rf_idx | output | 5 | Register write index |
| rf_data | output | 64 | Register write data |
| rf_dbl | output | 1 | Write is a 64-bit register |
| done | output | 1 | Completion pulse |
| done_err | output | 1 | Request refused, valid with done |
| base_we | output | 1 | Base writeback enable, valid with done |
| base_val | output | 32 | Updated base value, valid with done |

## Verification
A wrong address counter shows up on the very next read handshake as an address off its arithmetic slot. A stuck or flipped half-word staging flag shows up on the first double-precision write as swapped or repeated halves. A register-index counter that drifts gives a wrong rf_idx on the write where it drifts. A word-countdown error gives too few or too many writes, or a completion pulse that never comes, and this is seen when the transfer ends. Writeback and range errors appear only on the completion cycle, so every request is checked there against base±4×count and against the range rule.

// File: rtl/fpl_pkg.sv
package fpl_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  // Size of the whole transfer window in bytes.
  function automatic logic [ADDR_W-1:0] span_bytes(input logic [CNT_W-1:0] cnt);
    return ADDR_W'(cnt) << 2;
  endfunction

  // Lowest address of the window; reads always climb from here.
  function automatic logic [ADDR_W-1:0] first_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [CNT_W-1:0] cnt,
                                                   input logic add);
    return add ? base : base - span_bytes(cnt);
  endfunction

  // Base value handed back for writeback.
  function automatic logic [ADDR_W-1:0] final_base(input logic [ADDR_W-1:0] base,
                                                   input logic [CNT_W-1:0] cnt,
                                                   input logic add);
    return add ? base + span_bytes(cnt) : base - span_bytes(cnt);
  endfunction

  function automatic logic [CNT_W-1:0] reg_total(input logic [CNT_W-1:0] cnt,
                                                 input logic dbl);
    return dbl ? (cnt >> 1) : cnt;
  endfunction

  function automatic logic [CNT_W:0] word_total(input logic [CNT_W-1:0] regs,
                                                input logic dbl);
    return dbl ? ({1'b0, regs} << 1) : {1'b0, regs};
  endfunction

  function automatic logic [2*WORD_W-1:0] pack_pair(input logic [WORD_W-1:0] first_w,
                                                    input logic [WORD_W-1:0] second_w,
                                                    input logic big);
    return big ? {first_w, second_w} : {second_w, first_w};
  endfunction
endpackage

// File: rtl/fpl_addr_gen.sv
module fpl_addr_gen
  import fpl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      addr_q <= '0;
    else if (load_i) addr_q <= load_addr_i;
    else if (step_i) addr_q <= addr_q + WORD_BYTES;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/fpl_word_pack.sv
module fpl_word_pack
  import fpl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                word_valid_i,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                dbl_i,
  input  logic                big_i,
  output logic                out_valid_o,
  output logic [2*WORD_W-1:0] out_data_o
);
  logic              half_q;
  logic [WORD_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      stage_q <= '0;
    end else if (clear_i) begin
      half_q  <= 1'b0;
    end else if (word_valid_i && dbl_i) begin
      half_q <= ~half_q;
      if (!half_q) stage_q <= word_i;
    end
  end

  assign out_valid_o = word_valid_i && (!dbl_i || half_q);
  assign out_data_o  = dbl_i ? pack_pair(stage_q, word_i, big_i)
                             : {{WORD_W{1'b0}}, word_i};

  AST_PAIR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !half_q); // R3
  AST_SINGLE_NO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl_i && !clear_i && !half_q) |=> !half_q); // R2
endmodule

// File: rtl/fpl_seq_ctrl.sv
module fpl_seq_ctrl
  import fpl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid_i,
  input  logic [CNT_W:0] nwords_i,
  input  logic           bad_i,
  input  logic           mem_ready_i,
  input  logic           rsp_valid_i,
  output logic           accept_o,
  output logic           busy_o,
  output logic           rd_valid_o,
  output logic           step_o,
  output logic           done_o
);
  seq_state_e     state_q;
  logic [CNT_W:0] words_left_q;
  logic           last_word;

  assign accept_o   = req_valid_i && (state_q == ST_IDLE);
  assign busy_o     = (state_q != ST_IDLE);
  assign rd_valid_o = (state_q == ST_ISSUE);
  assign step_o     = (state_q == ST_WAIT) && rsp_valid_i;
  assign done_o     = (state_q == ST_DONE);
  assign last_word  = (words_left_q == (CNT_W+1)'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      words_left_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          words_left_q <= nwords_i;
          state_q      <= (bad_i || nwords_i == '0) ? ST_DONE : ST_ISSUE;
        end
        ST_ISSUE: if (mem_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          words_left_q <= words_left_q - 1'b1;
          state_q      <= last_word ? ST_DONE : ST_ISSUE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_ISSUE_HAS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> words_left_q != '0); // R6
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_valid_i) |=> $stable(words_left_q) || $past(step_o)); // R9
endmodule

// File: rtl/fp_multi_loader.sv
module fp_multi_loader
  import fpl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_base,
  input  logic [IDX_W-1:0]  req_start,
  input  logic [7:0]        req_count,
  input  logic              req_dbl,
  input  logic              req_add,
  input  logic              req_wback,
  input  logic              req_big,
  output logic              busy,
  output logic              mem_rd_valid,
  output logic [31:0]       mem_rd_addr,
  input  logic              mem_rd_ready,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [63:0]       rf_data,
  output logic              rf_dbl,
  output logic              done,
  output logic              done_err,
  output logic              base_we,
  output logic [31:0]       base_val
);
  localparam int NUM_REGS = 1 << IDX_W;
  localparam int REACH_W  = (CNT_W > IDX_W ? CNT_W : IDX_W) + 2;

  // request decode
  logic [CNT_W-1:0]   req_regs;
  logic [REACH_W-1:0] req_reach;
  logic               req_bad;
  logic [CNT_W:0]     req_words;

  assign req_regs  = reg_total(req_count, req_dbl);
  assign req_reach = REACH_W'(req_start) + REACH_W'(req_regs);
  assign req_bad   = req_reach > REACH_W'(NUM_REGS);
  assign req_words = req_bad ? '0 : word_total(req_regs, req_dbl);

  // internal events, named for the checks
  logic              accept, step, seq_busy, seq_rd, seq_done;
  logic              pack_valid;
  logic [2*WORD_W-1:0] pack_data;
  logic [ADDR_W-1:0] cur_addr;

  // latched request context
  logic              dbl_q, big_q, wb_q, err_q;
  logic [ADDR_W-1:0] wb_base_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbl_q     <= 1'b0;
      big_q     <= 1'b0;
      wb_q      <= 1'b0;
      err_q     <= 1'b0;
      wb_base_q <= '0;
      idx_q     <= '0;
    end else if (accept) begin
      dbl_q     <= req_dbl;
      big_q     <= req_big;
      wb_q      <= req_wback;
      err_q     <= req_bad;
      wb_base_q <= final_base(req_base, req_count, req_add);
      idx_q     <= req_start;
    end else if (pack_valid) begin
      idx_q     <= idx_q + 1'b1;
    end
  end

  fpl_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid),
    .nwords_i    (req_words),
    .bad_i       (req_bad),
    .mem_ready_i (mem_rd_ready),
    .rsp_valid_i (mem_rsp_valid),
    .accept_o    (accept),
    .busy_o      (seq_busy),
    .rd_valid_o  (seq_rd),
    .step_o      (step),
    .done_o      (seq_done)
  );

  fpl_addr_gen u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept),
    .load_addr_i (first_addr(req_base, req_count, req_add)),
    .step_i      (step),
    .addr_o      (cur_addr)
  );

  fpl_word_pack u_pack (
    .clk          (clk),
    .rst_n        (rst_n),
    .clear_i      (accept),
    .word_valid_i (step),
    .word_i       (mem_rsp_data),
    .dbl_i        (dbl_q),
    .big_i        (big_q),
    .out_valid_o  (pack_valid),
    .out_data_o   (pack_data)
  );

  assign busy         = seq_busy;
  assign mem_rd_valid = seq_rd;
  assign mem_rd_addr  = cur_addr;
  assign rf_we        = pack_valid;
  assign rf_idx       = idx_q;
  assign rf_data      = pack_data;
  assign rf_dbl       = dbl_q;
  assign done         = seq_done;
  assign done_err     = seq_done && err_q;
  assign base_we      = seq_done && wb_q && !err_q;
  assign base_val     = wb_base_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr)); // R8
  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> busy && !done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && err_q) |-> !mem_rd_valid && !rf_we); // R7
  AST_ADDR_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept && $past(mem_rsp_valid) && $past(mem_rd_valid) == 1'b0
     && mem_rd_valid && $rose(mem_rd_valid)) |-> mem_rd_addr == $past(mem_rd_addr) + 32'd4); // R1
endmodule

// File: tb/fp_multi_loader_tb_top.sv
module fp_multi_loader_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_base = '0;
  logic [4:0]  req_start = '0;
  logic [7:0]  req_count = '0;
  logic        req_dbl = 1'b0, req_add = 1'b0, req_wback = 1'b0, req_big = 1'b0;
  logic        busy, mem_rd_valid, rf_we, rf_dbl, done, done_err, base_we;
  logic [31:0] mem_rd_addr, base_val;
  logic        mem_rd_ready, mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_multi_loader dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
    .req_start(req_start), .req_count(req_count), .req_dbl(req_dbl),
    .req_add(req_add), .req_wback(req_wback), .req_big(req_big), .busy(busy),
    .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_data(rf_data), .rf_dbl(rf_dbl), .done(done), .done_err(done_err),
    .base_we(base_we), .base_val(base_val)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  function automatic logic [31:0] mw(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // memory stand-in: pseudo-random ready and response latency
  logic [15:0] rng;
  logic        pend;
  logic [1:0]  lat;
  logic [31:0] paddr;
  always @(posedge clk) begin
    if (!rst_n) begin
      rng <= 16'hACE1; pend <= 1'b0; lat <= '0; paddr <= '0;
      mem_rd_ready <= 1'b0; mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
    end else begin
      rng <= {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
      mem_rd_ready  <= rng[0] | rng[3];
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (lat == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= mw(paddr);
          pend          <= 1'b0;
        end else lat <= lat - 2'd1;
      end else if (mem_rd_valid && mem_rd_ready) begin
        pend <= 1'b1; paddr <= mem_rd_addr; lat <= rng[5:4];
      end
    end
  end

  // transaction context used by the monitor
  bit          tx_active = 0;
  logic [31:0] tx_first;
  int          tx_start, wr_seen, rd_seen;
  bit          tx_dbl, tx_big;
  bit          hold_prev = 0;
  logic [31:0] prev_addr;

  always @(negedge clk) begin
    if (rst_n && tx_active) begin
      if (rf_we) begin
        logic [63:0] exp;
        if (tx_dbl) begin
          logic [31:0] w1, w2;
          w1 = mw(tx_first + 32'(8 * wr_seen));
          w2 = mw(tx_first + 32'(8 * wr_seen + 4));
          exp = tx_big ? {w1, w2} : {w2, w1};
          check(rf_data == exp, "R3", "double data", rf_data, exp);
        end else begin
          exp = {32'h0, mw(tx_first + 32'(4 * wr_seen))};
          check(rf_data == exp, "R2", "single data", rf_data, exp);
        end
        check(rf_dbl == tx_dbl, tx_dbl ? "R3" : "R2", "rf_dbl", 64'(rf_dbl), 64'(tx_dbl));
        check(rf_idx == 5'(tx_start + wr_seen), "R4", "rf_idx", 64'(rf_idx),
              64'(5'(tx_start + wr_seen)));
        wr_seen++;
      end
      if (mem_rd_valid) begin
        if (hold_prev)
          check(mem_rd_addr == prev_addr, "R8", "addr hold", 64'(mem_rd_addr), 64'(prev_addr));
        if (mem_rd_ready) begin
          check(mem_rd_addr == tx_first + 32'(4 * rd_seen), "R1", "read addr",
                64'(mem_rd_addr), 64'(tx_first + 32'(4 * rd_seen)));
          rd_seen++;
        end
      end else if (hold_prev) begin
        check(1'b0, "R8", "valid dropped", 64'(0), 64'(1));
      end
      hold_prev = mem_rd_valid && !mem_rd_ready;
      prev_addr = mem_rd_addr;
    end else begin
      hold_prev = 0;
    end
  end

  task automatic run_tx(input logic [31:0] base, input int start, input int cnt,
                        input bit dbl, input bit add, input bit big, input bit wb,
                        input bit noise);
    int regs, words, cyc;
    bit bad, got;
    logic [31:0] exp_wb;
    regs   = dbl ? cnt / 2 : cnt;
    bad    = (start + regs) > 32;
    words  = bad ? 0 : (dbl ? 2 * regs : regs);
    exp_wb = add ? base + 32'(4 * cnt) : base - 32'(4 * cnt);
    @(negedge clk);
    tx_first = add ? base : base - 32'(4 * cnt);
    tx_start = start; tx_dbl = dbl; tx_big = big;
    wr_seen = 0; rd_seen = 0; tx_active = 1;
    req_base = base; req_start = 5'(start); req_count = 8'(cnt);
    req_dbl = dbl; req_add = add; req_big = big; req_wback = wb;
    req_valid = 1'b1;
    cyc = 0; got = 0;
    while (!got && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) check(busy == 1'b1, "R9", "busy after accept", 64'(busy), 64'(1));
      req_valid = noise;
      if (noise) begin
        req_base = ~base; req_start = 5'(start + 3); req_count = 8'(cnt + 5);
        req_dbl = ~dbl; req_add = ~add; req_big = ~big; req_wback = ~wb;
      end
      if (done) got = 1;
    end
    req_valid = 1'b0;
    check(got, "R10", "done seen", 64'(got), 64'(1));
    check(wr_seen == (bad ? 0 : regs), bad ? "R7" : "R4", "write count",
          64'(wr_seen), 64'(bad ? 0 : regs));
    check(rd_seen == words, "R1", "read count", 64'(rd_seen), 64'(words));
    check(done_err == bad, "R7", "done_err", 64'(done_err), 64'(bad));
    check(base_we == (wb && !bad), "R5", "base_we", 64'(base_we), 64'(wb && !bad));
    if (wb && !bad) check(base_val == exp_wb, "R5", "base_val", 64'(base_val), 64'(exp_wb));
    if (words == 0) check(cyc == 1, "R6", "immediate done", 64'(cyc), 64'(1));
    @(negedge clk);
    check(!done && !busy, "R10", "pulse ends", {62'h0, done, busy}, 64'(0));
    tx_active = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 64'(0), 64'(1));
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !mem_rd_valid && !rf_we, "R9", "reset state",
          {60'h0, busy, done, mem_rd_valid, rf_we}, 64'(0));
    // sweep of counts and mode bits
    for (int c = 0; c < 10; c++)
      for (int m = 0; m < 16; m++)
        run_tx(32'h0000_4000 + 32'(c * 64 + m * 4), (c * 7) % 20, c,
               m[0], m[1], m[2], m[3], bit'((c + m) % 3 == 0));
    // range edges and odd double counts
    run_tx(32'h0000_8000, 24, 8, 0, 1, 0, 1, 0);   // R4 reaches last register
    run_tx(32'h0000_8000, 31, 1, 0, 0, 0, 1, 1);   // R4
    run_tx(32'h0000_8000, 31, 2, 0, 1, 0, 1, 0);   // R7
    run_tx(32'h0000_8000, 29, 6, 1, 1, 1, 1, 0);   // R3 three doubles to the end
    run_tx(32'h0000_8000, 30, 6, 1, 0, 1, 1, 1);   // R7
    run_tx(32'h0000_9000, 0, 255, 0, 1, 0, 1, 0);  // R7
    run_tx(32'h0000_9000, 2, 1, 1, 0, 0, 1, 0);    // R6 no registers, base moves
    run_tx(32'h0000_9000, 4, 7, 1, 1, 0, 1, 0);    // R4 bit 0 ignored
    run_tx(32'h0000_0008, 0, 4, 0, 0, 1, 1, 0);    // R1 window ends at base
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule